// File: doc/BRIEF.md
# Serial DAC Frame Controller

This block sends one 16-bit word to an external serial DAC for each convert request it receives. The word has two parts. The first is an 8-bit control byte, which tells the DAC which channel to load and how. The second is the 8-bit sample value. The block runs entirely in the slow 30 MHz serial-clock domain. The convert strobe arriving from the fast domain must already be synchronized before it reaches this block.

When a request is accepted, the block captures the control byte and the sample in a shift register and presets a bit counter to 15. It then drives the frame-sync low for one lead cycle. After that it shifts the word out MSB first, one bit per serial clock, while the counter steps down to 0.

Every register in the block is clocked on the falling edge of the slow clock. As a result, the frame-sync, the serial-clock enable and the data line all settle half a period away from the rising edge at which the DAC samples. The block reports a busy level and a one-cycle done pulse, which the fast domain can use to pace its requests.

Top module: `dac_frame_ctrl`

## Requirements
- R1: While rstN is low and directly after it rises, the outputs are: syncN high, sclkEn low, busy low, done low, sdata low.
- R2: When no convert is seen, the block stays idle: syncN stays high, sclkEn stays low and busy stays low.
- R3: A convert seen high at a falling clock edge while idle is accepted at that edge. For the one following cycle, syncN is low, busy is high and sclkEn is low. This is the lead cycle.
- R4: After the lead cycle there are exactly 16 shift cycles. In each of them sclkEn is high and syncN is low. sdata carries ctrlByte bits 7 down to 0 and then sampleByte bits 7 down to 0, one bit per cycle.
- R5: ctrlByte and sampleByte are captured at the edge that accepts convert. Changing them later does not alter the frame being sent.
- R6: At the falling edge that ends the bit-0 cycle, syncN returns high and sclkEn returns low.
- R7: A convert that arrives during the lead or shift cycles is ignored. No further frame follows the current one.
- R8: busy is high for exactly the 17 cycles of the lead and shift phases. done is high for exactly one cycle, the first cycle after the frame.
- R9: A convert seen in the cycle in which done is high is accepted, and the next frame starts immediately.
- R10: Outputs change only at falling clock edges. A value seen just after a rising edge is still present just before the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow serial clock (30 MHz); all registers use its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| convert | input | 1 | Synchronized request to send one frame |
| ctrlByte | input | 8 | Control byte, sent first, MSB first |
| sampleByte | input | 8 | Sample value, sent second, MSB first |
| syncN | output | 1 | Active-low frame sync to the DAC |
| sclkEn | output | 1 | Serial-clock enable; high in the 16 bit cycles |
| sdata | output | 1 | Serial data to the DAC |
| busy | output | 1 | High from accept until the last bit ends |
| done | output | 1 | One-cycle pulse after each frame |

## Verification
Frames are sent with several word patterns, and each one separates a different fault. 0xA5/0x3C checks the alternating bit order. 0x80/0x01 shows whether the shift runs in the wrong direction. All-ones against all-zeros halves show whether the bytes are swapped or a bit position is stuck. Other runs scramble the inputs after the accept, assert convert in the middle of a frame, and request a new frame in the done cycle. These tell a register that captures its inputs apart from one that is transparent. They also show whether a mid-frame convert is properly dropped, and whether back-to-back frames start without a gap. Each bit is sampled twice, just after a rising edge and just before the next falling edge, to confirm that outputs change only on falling edges.

// File: rtl/dacfc_pkg.sv
package dacfc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2
  } frame_state_t;

  typedef struct packed {
    logic load;
    logic shift;
  } dp_ctrl_t;

endpackage

// File: rtl/dacfc_datapath.sv
module dacfc_datapath
  import dacfc_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctrl_t            dpCtrl,
  input  logic [CTRL_W-1:0]   ctrlByte,
  input  logic [SAMPLE_W-1:0] sampleByte,
  output logic                serialOut,
  output logic                lastBit
);
  localparam int FRAME_W = CTRL_W + SAMPLE_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (dpCtrl.load) begin
      shiftReg <= {ctrlByte, sampleByte};
      bitCnt   <= LAST_IDX;
    end else if (dpCtrl.shift) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      bitCnt   <= bitCnt - CNT_W'(1);
    end
  end

  assign serialOut = shiftReg[FRAME_W-1];
  assign lastBit   = (bitCnt == '0);

  // R3: an accept presets the counter to the top bit index
  p_load_preset_r3: assert property (@(negedge clk) disable iff (!rstN)
    dpCtrl.load |=> bitCnt == LAST_IDX);

  // R4: each shift steps the counter down by one
  p_count_step_r4: assert property (@(negedge clk) disable iff (!rstN)
    (dpCtrl.shift && !lastBit) |=> bitCnt == $past(bitCnt) - CNT_W'(1));

  // R4: load and shift never coincide
  p_strobe_excl_r4: assert property (@(negedge clk) disable iff (!rstN)
    !(dpCtrl.load && dpCtrl.shift));

endmodule

// File: rtl/dacfc_control.sv
module dacfc_control
  import dacfc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     convert,
  input  logic     lastBit,
  output dp_ctrl_t dpCtrl,
  output logic     syncN,
  output logic     sclkEn,
  output logic     busy,
  output logic     done
);
  frame_state_t state, stateNext;
  logic         doneReg;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (convert) stateNext = ST_LEAD;
      ST_LEAD:  stateNext = ST_SHIFT;
      ST_SHIFT: if (lastBit) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= (state == ST_SHIFT) && lastBit;
    end
  end

  assign dpCtrl.load  = (state == ST_IDLE) && convert;
  assign dpCtrl.shift = (state == ST_SHIFT);

  assign busy   = (state != ST_IDLE);
  assign syncN  = !busy;
  assign sclkEn = (state == ST_SHIFT);
  assign done   = doneReg;

  // R4: serial clock only runs inside a sync window
  p_sclk_in_sync_r4: assert property (@(negedge clk) disable iff (!rstN)
    sclkEn |-> !syncN);

  // R8: done lasts a single cycle
  p_done_single_r8: assert property (@(negedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: the frame has fully closed when done is raised
  p_done_closed_r6: assert property (@(negedge clk) disable iff (!rstN)
    done |-> (syncN && !sclkEn && !busy));

  // R3: sync falls into a lead cycle without serial clock
  p_lead_cycle_r3: assert property (@(negedge clk) disable iff (!rstN)
    $fell(syncN) |-> !sclkEn);

  // R7: once busy, the frame is not restarted by convert
  p_no_restart_r7: assert property (@(negedge clk) disable iff (!rstN)
    (busy && !dpCtrl.shift) |-> !dpCtrl.load);

endmodule

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
  import dacfc_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                convert,
  input  logic [CTRL_W-1:0]   ctrlByte,
  input  logic [SAMPLE_W-1:0] sampleByte,
  output logic                syncN,
  output logic                sclkEn,
  output logic                sdata,
  output logic                busy,
  output logic                done
);
  dp_ctrl_t dpCtrl;
  logic     lastBit;

  dacfc_control i_control (
    .clk     (clk),
    .rstN    (rstN),
    .convert (convert),
    .lastBit (lastBit),
    .dpCtrl  (dpCtrl),
    .syncN   (syncN),
    .sclkEn  (sclkEn),
    .busy    (busy),
    .done    (done)
  );

  dacfc_datapath #(
    .CTRL_W   (CTRL_W),
    .SAMPLE_W (SAMPLE_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtrl     (dpCtrl),
    .ctrlByte   (ctrlByte),
    .sampleByte (sampleByte),
    .serialOut  (sdata),
    .lastBit    (lastBit)
  );

endmodule

// File: tb/test_dac_frame_ctrl.sv
`timescale 1ns/1ps
module test_dac_frame_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convert = 1'b0;
  logic [7:0] ctrlByte = '0;
  logic [7:0] sampleByte = '0;
  logic       syncN, sclkEn, sdata, busy, done;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  dac_frame_ctrl i_dac_frame_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .convert    (convert),
    .ctrlByte   (ctrlByte),
    .sampleByte (sampleByte),
    .syncN      (syncN),
    .sclkEn     (sclkEn),
    .sdata      (sdata),
    .busy       (busy),
    .done       (done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // outputs packed as {syncN, sclkEn, busy, done}
  function automatic logic [15:0] ctl();
    return {12'd0, syncN, sclkEn, busy, done};
  endfunction

  // Starts at a rising edge with the block idle.
  task automatic run_frame(input logic [7:0] c, input logic [7:0] s,
                           input bit scramble, input int midConv, input bit chain);
    logic [15:0] word;
    word = {c, s};
    convert = 1'b1; ctrlByte = c; sampleByte = s;
    @(posedge clk);
    convert = 1'b0;
    chk("R3 lead", ctl(), 16'b0010);
    if (scramble) begin ctrlByte = ~c; sampleByte = ~s; end
    for (int k = 0; k < 16; k++) begin
      @(posedge clk);
      convert = (k == midConv);
      chk("R4 ctl", ctl(), 16'b0110);
      chk(scramble ? "R5 bit" : "R4 bit", {15'd0, sdata}, {15'd0, word[15-k]});
      #2;
      chk("R10 hold", {14'd0, sdata, syncN}, {14'd0, word[15-k], 1'b0});
    end
    @(posedge clk);
    convert = chain;
    if (chain) begin ctrlByte = s; sampleByte = c; end
    chk("R6 R8 end", ctl(), 16'b1001);
  endtask

  task automatic t_reset();
    chk("R1 reset", {11'd0, sdata, ctl()}, 16'b01000);
    @(posedge clk);
    rstN = 1'b1;
    @(posedge clk);
    chk("R1 post", {11'd0, sdata, ctl()}, 16'b01000);
  endtask

  task automatic t_idle();
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      chk("R2 idle", ctl(), 16'b1000);
    end
  endtask

  task automatic t_pattern(input logic [7:0] c, input logic [7:0] s);
    run_frame(c, s, 1'b0, -1, 1'b0);
    @(posedge clk);
    chk("R8 done drop", ctl(), 16'b1000);
  endtask

  task automatic t_scramble();
    run_frame(8'h5A, 8'hC3, 1'b1, -1, 1'b0);
    @(posedge clk);
    chk("R8 done drop", ctl(), 16'b1000);
  endtask

  task automatic t_ignore();
    run_frame(8'h12, 8'h34, 1'b0, 5, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      chk("R7 ignored", ctl(), 16'b1000);
    end
  endtask

  task automatic t_chain();
    run_frame(8'hC0, 8'h0F, 1'b0, -1, 1'b1);
    run_frame(8'h0F, 8'hC0, 1'b0, -1, 1'b0);
    @(posedge clk);
    chk("R9 chain idle", ctl(), 16'b1000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_idle();
        t_pattern(8'hA5, 8'h3C);
        t_pattern(8'h80, 8'h01);
        t_pattern(8'hFF, 8'h00);
        t_pattern(8'h00, 8'hFF);
        t_scramble();
        t_ignore();
        t_chain();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule